// File: doc/BRIEF.md
# Interleaved Memory Line-Fill Controller

This block loads one 128-byte cache line from a main memory made of four independent 32-bit memory banks. A requester presents a byte address. The controller clears the address's offset within the line and walks the 32 words of the line in ascending order. It works out which bank holds each word and where the word sits inside that bank, then sends one read command to that bank. The words come back over a single 32-bit output, each with a valid strobe and its position in the line. A one-cycle completion pulse follows the last word.

A parameter selects how the banks share the address space. In the low-order variant, neighbouring words sit in neighbouring banks, so four reads can be in flight at once and the line streams out at one word per cycle. In the high-order variant, each bank owns one contiguous quarter of memory, so every word of a line comes from the same bank and the reads run one after another. Each bank is busy for four cycles per access and takes no new command during that time. The fill latency therefore depends on the variant.

Top module: `linefill_ctrl`

## Requirements
- R1: After a synchronous reset, busy, fill_valid, fill_done and every bit of mem_cmd_valid are 0.
- R2: A request is accepted on a clock edge where req_valid is 1 and busy is 0. Address bits [6:0] are treated as zero, so any address inside a line fills that whole line. busy is 1 in the cycle after acceptance.
- R3: With the low-order variant, the word at byte address A is read from bank A[3:2] at bank word index A[31:4].
- R4: With the high-order variant, the word at byte address A is read from bank A[31:30] at bank word index A[29:2].
- R5: The 32 words of a line appear on fill_data, each marked by one fill_valid cycle. fill_idx runs 0,1,...,31 in ascending address order.
- R6: With the low-order variant and 4-cycle banks, word k is on the output in the cycle after edge k+5, where edge 0 is the accepting edge. fill_done is high in the cycle after edge 37.
- R7: With the high-order variant, word k is on the output in the cycle after edge 4k+5, and fill_done is high in the cycle after edge 130.
- R8: A bank never receives a new command fewer than 4 cycles after its previous one.
- R9: At most one bit of mem_cmd_valid is high in any cycle.
- R10: busy stays high from acceptance until the last word has been output, and it is low in the fill_done cycle. A request raised while busy is 1 is ignored and starts no later fill.
- R11: fill_done is a single-cycle pulse that comes in the cycle right after the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fill request strobe |
| req_addr | input | 32 | Byte address inside the line to fill |
| busy | output | 1 | Fill in progress; requests ignored |
| mem_cmd_valid | output | 4 | One-hot read command, one bit per bank |
| mem_cmd_word | output | 28 | Word index inside the addressed bank |
| mem_rsp_valid | input | 4 | Read data valid, one bit per bank |
| mem_rsp_data | input | 128 | Read data, bank b in bits [32b+31:32b] |
| fill_valid | output | 1 | fill_data and fill_idx hold a line word |
| fill_idx | output | 5 | Position of the word within the line |
| fill_data | output | 32 | Line word |
| fill_done | output | 1 | One-cycle pulse after the last word |

## Verification
The bench builds two copies with the default 32-bit address, 4 banks, 128-byte line and 4-cycle bank latency. One copy uses the low-order variant and the other the high-order variant, and both receive the same requests. Each bank model returns a word that encodes its own bank number and word index, so an arithmetic expectation of both mapping equations catches any mis-routed read. The address sweep covers unaligned offsets, the ends of memory and the edges of the quarter-sized bank regions. The exact arrival cycle of every word is checked in both variants, together with the fill latency, the bank spacing and requests held high through a fill.

// File: rtl/linefill_pkg.sv
package linefill_pkg;

  typedef enum logic {
    ILV_LOW  = 1'b0,
    ILV_HIGH = 1'b1
  } ilv_mode_e;

endpackage

// File: rtl/lf_addr_map.sv
module lf_addr_map
  import linefill_pkg::*;
#(
  parameter int        WORD_W   = 30,
  parameter int        BANK_W   = 2,
  parameter ilv_mode_e ILV_MODE = ILV_LOW,
  localparam int       LOCAL_W  = WORD_W - BANK_W
) (
  input  logic [WORD_W-1:0]  word_addr,
  output logic [BANK_W-1:0]  bank,
  output logic [LOCAL_W-1:0] local_idx
);

  generate
    if (ILV_MODE == ILV_LOW) begin : g_low
      assign bank      = word_addr[BANK_W-1:0];
      assign local_idx = word_addr[WORD_W-1:BANK_W];
    end else begin : g_high
      assign bank      = word_addr[WORD_W-1:LOCAL_W];
      assign local_idx = word_addr[LOCAL_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/lf_bank_timer.sv
module lf_bank_timer #(
  parameter int  LAT = 4,
  localparam int CW  = $clog2(LAT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic issue_i,
  output logic ready_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (issue_i) begin
      cnt_q <= CW'(LAT - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ready_o = (cnt_q == '0);

  generate
    if (LAT > 1) begin : g_gap_chk
      p_bank_gap_r8: assert property (@(posedge clk) disable iff (rst)
        issue_i |=> !issue_i);
    end
  endgenerate

endmodule

// File: rtl/lf_resp_collect.sv
module lf_resp_collect #(
  parameter int NB     = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear_i,
  input  logic [NB-1:0]        rsp_valid_i,
  input  logic [NB*DATA_W-1:0] rsp_data_i,
  output logic                 out_valid_o,
  output logic [IDX_W-1:0]     out_idx_o,
  output logic [DATA_W-1:0]    out_data_o
);

  logic [DATA_W-1:0] sel_data;
  logic              any_rsp;
  logic [IDX_W-1:0]  next_idx_q;

  always_comb begin
    sel_data = '0;
    for (int b = 0; b < NB; b++) begin
      if (rsp_valid_i[b]) sel_data = rsp_data_i[b*DATA_W +: DATA_W];
    end
  end

  assign any_rsp = |rsp_valid_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      out_idx_o   <= '0;
      out_data_o  <= '0;
      next_idx_q  <= '0;
    end else begin
      out_valid_o <= any_rsp;
      if (any_rsp) begin
        out_data_o <= sel_data;
        out_idx_o  <= next_idx_q;
        next_idx_q <= next_idx_q + 1'b1;
      end
      if (clear_i) next_idx_q <= '0;
    end
  end

  p_rsp_single_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rsp_valid_i));

endmodule

// File: rtl/linefill_ctrl.sv
module linefill_ctrl
  import linefill_pkg::*;
#(
  parameter int        ADDR_W     = 32,
  parameter int        DATA_W     = 32,
  parameter int        LINE_BYTES = 128,
  parameter int        NUM_BANKS  = 4,
  parameter int        MEM_LAT    = 4,
  parameter ilv_mode_e ILV_MODE   = ILV_LOW,
  localparam int       BYTE_OFF   = $clog2(DATA_W / 8),
  localparam int       WORD_W     = ADDR_W - BYTE_OFF,
  localparam int       LINE_WORDS = LINE_BYTES / (DATA_W / 8),
  localparam int       IDX_W      = $clog2(LINE_WORDS),
  localparam int       BANK_W     = $clog2(NUM_BANKS),
  localparam int       LOCAL_W    = WORD_W - BANK_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [ADDR_W-1:0]           req_addr,
  output logic                        busy,
  output logic [NUM_BANKS-1:0]        mem_cmd_valid,
  output logic [LOCAL_W-1:0]          mem_cmd_word,
  input  logic [NUM_BANKS-1:0]        mem_rsp_valid,
  input  logic [NUM_BANKS*DATA_W-1:0] mem_rsp_data,
  output logic                        fill_valid,
  output logic [IDX_W-1:0]            fill_idx,
  output logic [DATA_W-1:0]           fill_data,
  output logic                        fill_done
);

  logic                 busy_q;
  logic [WORD_W-1:0]    base_word_q;
  logic [IDX_W:0]       iss_cnt_q;
  logic [WORD_W-1:0]    cur_word;
  logic [BANK_W-1:0]    cur_bank;
  logic [LOCAL_W-1:0]   cur_local;
  logic [NUM_BANKS-1:0] bank_ready;
  logic [NUM_BANKS-1:0] iss_vec;
  logic                 issue_ok;
  logic                 accept;
  logic                 last_out;

  assign accept   = req_valid && !busy_q;
  assign cur_word = base_word_q + WORD_W'(iss_cnt_q[IDX_W-1:0]);

  lf_addr_map #(
    .WORD_W  (WORD_W),
    .BANK_W  (BANK_W),
    .ILV_MODE(ILV_MODE)
  ) u_map (
    .word_addr(cur_word),
    .bank     (cur_bank),
    .local_idx(cur_local)
  );

  assign issue_ok = busy_q && !iss_cnt_q[IDX_W] && bank_ready[cur_bank];
  assign iss_vec  = issue_ok ? (NUM_BANKS'(1) << cur_bank) : '0;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      lf_bank_timer #(.LAT(MEM_LAT)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .issue_i(iss_vec[b]),
        .ready_o(bank_ready[b])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q        <= 1'b0;
      base_word_q   <= '0;
      iss_cnt_q     <= '0;
      mem_cmd_valid <= '0;
      mem_cmd_word  <= '0;
      fill_done     <= 1'b0;
    end else begin
      mem_cmd_valid <= iss_vec;
      fill_done     <= last_out;
      if (issue_ok) begin
        mem_cmd_word <= cur_local;
        iss_cnt_q    <= iss_cnt_q + 1'b1;
      end
      if (accept) begin
        busy_q      <= 1'b1;
        iss_cnt_q   <= '0;
        base_word_q <= WORD_W'((req_addr & ~ADDR_W'(LINE_BYTES - 1)) >> BYTE_OFF);
      end else if (last_out) begin
        busy_q <= 1'b0;
      end
    end
  end

  lf_resp_collect #(
    .NB    (NUM_BANKS),
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) u_collect (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (accept),
    .rsp_valid_i(mem_rsp_valid),
    .rsp_data_i (mem_rsp_data),
    .out_valid_o(fill_valid),
    .out_idx_o  (fill_idx),
    .out_data_o (fill_data)
  );

  assign last_out = fill_valid && (fill_idx == IDX_W'(LINE_WORDS - 1));
  assign busy     = busy_q;

  p_cmd_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mem_cmd_valid));

  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    fill_done |-> !busy);

  p_out_busy_r10: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> busy);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    fill_done |=> !fill_done);

endmodule

// File: tb/linefill_ctrl_tb_top.sv
module lf_mem_model #(
  parameter int BANK    = 0,
  parameter int LAT     = 4,
  parameter int LOCAL_W = 28
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [LOCAL_W-1:0] cmd_word,
  output logic               rsp_valid,
  output logic [31:0]        rsp_data,
  output logic               viol
);
  logic               sv [LAT-1];
  logic [LOCAL_W-1:0] sw [LAT-1];
  int                 tick;
  int                 last_t;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT - 1; i++) begin
        sv[i] <= 1'b0;
        sw[i] <= '0;
      end
      tick   <= 0;
      last_t <= -1000;
      viol   <= 1'b0;
    end else begin
      tick   <= tick + 1;
      sv[0]  <= cmd_valid;
      sw[0]  <= cmd_word;
      for (int i = 1; i < LAT - 1; i++) begin
        sv[i] <= sv[i-1];
        sw[i] <= sw[i-1];
      end
      viol <= cmd_valid && (tick - last_t < LAT);
      if (cmd_valid) last_t <= tick;
    end
  end

  assign rsp_valid = sv[LAT-2];
  assign rsp_data  = {2'(BANK), sw[LAT-2], 2'b01};
endmodule

module linefill_ctrl_tb_top;
  import linefill_pkg::*;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [31:0]  req_addr = '0;

  logic         busy [2];
  logic [3:0]   cmd_v [2];
  logic [27:0]  cmd_w [2];
  logic [3:0]   rsp_v [2];
  logic [127:0] rsp_d [2];
  logic         f_valid [2];
  logic [4:0]   f_idx [2];
  logic [31:0]  f_data [2];
  logic         f_done [2];
  logic [3:0]   viol [2];

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int acc = 0;
  logic [31:0] exp_base = '0;
  int got_cnt [2];
  int done_cyc [2];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  linefill_ctrl #(.ILV_MODE(ILV_LOW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy[0]), .mem_cmd_valid(cmd_v[0]), .mem_cmd_word(cmd_w[0]),
    .mem_rsp_valid(rsp_v[0]), .mem_rsp_data(rsp_d[0]),
    .fill_valid(f_valid[0]), .fill_idx(f_idx[0]), .fill_data(f_data[0]),
    .fill_done(f_done[0]));

  linefill_ctrl #(.ILV_MODE(ILV_HIGH)) dut_hi_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy[1]), .mem_cmd_valid(cmd_v[1]), .mem_cmd_word(cmd_w[1]),
    .mem_rsp_valid(rsp_v[1]), .mem_rsp_data(rsp_d[1]),
    .fill_valid(f_valid[1]), .fill_idx(f_idx[1]), .fill_data(f_data[1]),
    .fill_done(f_done[1]));

  for (genvar d = 0; d < 2; d++) begin : g_dut
    for (genvar b = 0; b < 4; b++) begin : g_mem
      lf_mem_model #(.BANK(b)) u_mem (
        .clk(clk), .rst(rst), .cmd_valid(cmd_v[d][b]), .cmd_word(cmd_w[d]),
        .rsp_valid(rsp_v[d][b]), .rsp_data(rsp_d[d][b*32 +: 32]),
        .viol(viol[d][b]));
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] exp_word(input int m, input logic [31:0] base, input int k);
    logic [29:0] w;
    w = base[31:2] + 30'(k);
    if (m == 0) return {w[1:0], w[29:2], 2'b01};
    else        return {w[29:28], w[27:0], 2'b01};
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      for (int m = 0; m < 2; m++) begin
        chk($countones(cmd_v[m]) <= 1, "R9", "commands per cycle", $countones(cmd_v[m]), 1);
        if (viol[m] != 4'b0) chk(1'b0, "R8", "bank re-issued too early", viol[m], 0);
        if (f_valid[m]) begin
          chk(f_idx[m] == 5'(got_cnt[m]) && got_cnt[m] < 32, "R5", "word index",
              f_idx[m], got_cnt[m]);
          chk(f_data[m] == exp_word(m, exp_base, got_cnt[m]), (m == 0) ? "R3" : "R4",
              "word data", f_data[m], exp_word(m, exp_base, got_cnt[m]));
          chk(cyc == acc + 5 + got_cnt[m] * ((m == 0) ? 1 : 4), (m == 0) ? "R6" : "R7",
              "word arrival cycle", cyc, acc + 5 + got_cnt[m] * ((m == 0) ? 1 : 4));
          got_cnt[m]++;
        end
        if (f_done[m]) begin
          chk(!busy[m], "R10", "busy during done", busy[m], 0);
          chk(got_cnt[m] == 32, "R11", "done after last word", got_cnt[m], 32);
          done_cyc[m] = cyc;
        end
      end
    end
  end

  task automatic run_fill(input logic [31:0] addr, input bit hold_req);
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      got_cnt[m]  = 0;
      done_cyc[m] = -1;
    end
    exp_base  = addr & ~32'h7F;
    req_valid = 1'b1;
    req_addr  = addr;
    @(posedge clk);
    #1 acc = cyc;
    @(negedge clk);
    for (int m = 0; m < 2; m++) chk(busy[m], "R2", "busy after accept", busy[m], 1);
    if (hold_req) req_addr = addr ^ 32'h5A5A_5A00;
    else req_valid = 1'b0;
    for (int t = 0; t < 400 && (done_cyc[0] < 0 || done_cyc[1] < 0); t++) begin
      @(negedge clk);
      if (cyc == acc + 36) req_valid = 1'b0;
    end
    req_valid = 1'b0;
    chk(done_cyc[0] == acc + 37, "R6", "low-order done cycle", done_cyc[0], acc + 37);
    chk(done_cyc[1] == acc + 130, "R7", "high-order done cycle", done_cyc[1], acc + 130);
    for (int m = 0; m < 2; m++) chk(got_cnt[m] == 32, "R5", "word count", got_cnt[m], 32);
    repeat (4) @(negedge clk);
    for (int m = 0; m < 2; m++) chk(!busy[m], "R10", "idle after fill", busy[m], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      got_cnt[m]  = 0;
      done_cyc[m] = -1;
    end
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int m = 0; m < 2; m++) begin
      chk(!busy[m] && !f_valid[m] && !f_done[m] && cmd_v[m] == 4'b0, "R1", "reset outputs",
          {busy[m], f_valid[m], f_done[m], cmd_v[m]}, 0);
    end
    run_fill(32'h0000_0000, 1'b0);
    run_fill(32'h0000_007F, 1'b0);
    run_fill(32'h0000_0083, 1'b1);
    run_fill(32'h3FFF_FF80, 1'b0);
    run_fill(32'h4000_0005, 1'b0);
    run_fill(32'h7FFF_FFC1, 1'b1);
    run_fill(32'hBFFF_FF85, 1'b0);
    run_fill(32'hC000_0000, 1'b0);
    run_fill(32'hFFFF_FFFF, 1'b0);
    for (int i = 0; i < 6; i++) run_fill(32'h1357_9BDF * (i + 1) + 32'(i * 37), i[0]);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule